// File: doc/BRIEF.md
# Instruction Bundle Format Dispatcher

This block sits between instruction fetch and execute. It takes each 32-bit fetched word and reads the two top bits to find the word's format. The other 30 bits then hold either one long operation or two 15-bit short operations. The block puts out one operation per clock on a registered issue port. Each issued operation carries a payload, a valid strobe and a tag that says what kind of slot it came from. A pair of short operations is handed out over two consecutive cycles. The left field sits in bits 29:15 and the right field in bits 14:0.

Every operation is checked against a small opcode table before it is issued. Long and short operations use separate tables of 64 entries each. An operation that matches no entry raises a one-cycle fault instead of issuing.

Two inputs come back from execute and decide the second half of a pair. The first is a "PC changed" flag that answers the first operation of a sequential pair. The second is a condition result that answers a test-only operation in a parallel pair. The word interface accepts a new word only when no second half is still pending.

Top module: `bdisp_top`

## Requirements
- R1: A word with bits 31:30 = 11 holds one long operation. If it is legal, one cycle after acceptance the port shows op_valid=1, op_tag=1 and op_data = word bits 29:0.
- R2: A word with bits 31:30 = 10 holds two shorts, and the right field (bits 14:0) goes first. The port shows tag 3 with the right field. If pc_changed is low during that cycle, the next cycle shows tag 2 with the left field (bits 29:15). A short payload is the 15-bit field, zero-extended to 30 bits.
- R3: A word with bits 31:30 = 01 holds two shorts, and the left field goes first. The port shows tag 2 with the left field, then tag 3 with the right field.
- R4: In formats 10 and 01, if pc_changed is high during the cycle the first short is on the port, the second short is dropped. The next cycle shows op_valid=0, op_tag=7 and op_data=0.
- R5: A word with bits 31:30 = 00 and no test-only operation issues the left field and then the right field, both with tag 4, in consecutive cycles.
- R6: In format 00, a test-only operation is issued first with tag 5. If both fields are test-only, the left one takes precedence. The other field follows in the next cycle with tag 6 when cond_true is high during the test cycle; otherwise that cycle shows tag 7 with op_valid=0.
- R7: Opcode table rules. A long operation indexes the table with word bits 29:24 and is illegal when bits 29:28 = 11. A short operation indexes with its field bits 14:9 and is illegal when that index is 63. Short indices 56 to 62 are test-only and match only when field bit 8 is 0.
- R8: An illegal operation gives fault=1, op_valid=0 and op_tag=0 for one cycle, and nothing is issued in its place. In format 00 an illegal field in either slot faults the whole word. In formats 10 and 01 an illegal first field drops the word. An illegal second field faults only if it is not dropped under R4.
- R9: in_ready is low only during the single cycle in which a second short is pending. A word offered in that cycle is not taken.
- R10: After reset, op_valid=0, fault=0, op_tag=0, op_data=0 and in_ready=1.
- R11: The tag codes are 0 none, 1 long, 2 left, 3 right, 4 parallel, 5 condition test, 6 conditional execute and 7 skipped. op_valid is high exactly when the tag is 1 to 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_valid | input | 1 | A fetched word is offered |
| word_i | input | 32 | Fetched instruction word |
| in_ready | output | 1 | The block takes the offered word at this edge |
| pc_changed | input | 1 | The first sequential short changed the PC |
| cond_true | input | 1 | Result of the test-only operation |
| op_valid | output | 1 | An operation is issued this cycle |
| op_tag | output | 3 | Slot-type tag (codes in R11) |
| op_data | output | 30 | Issued operation payload |
| fault | output | 1 | Illegal-instruction fault pulse |

## Verification
The assertions check these rules on every cycle:
- a fault never comes with an issue;
- the busy window lasts one cycle;
- a legal long word appears on the port with its payload;
- a branch-skipped second slot shows as skipped;
- a parallel pair completes in the next cycle;
- the result that follows a condition test agrees with the sampled condition.

Only the bench's scenarios can show some other behaviour:
- the field order of each format;
- the table's legality rules, including the bit-8 match on test-only entries;
- left-over-right precedence when both fields are test-only;
- a word offered while the block is busy is really left untaken.

// File: rtl/bdisp_pkg.sv
package bdisp_pkg;

  typedef enum logic [2:0] {
    TG_NONE  = 3'd0,
    TG_LONG  = 3'd1,
    TG_LEFT  = 3'd2,
    TG_RIGHT = 3'd3,
    TG_PAR   = 3'd4,
    TG_CTEST = 3'd5,
    TG_CEXEC = 3'd6,
    TG_SKIP  = 3'd7
  } tag_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEQ2 = 2'd1,
    ST_PAR2 = 2'd2,
    ST_COND = 2'd3
  } st_e;

  // one opcode table entry: legal, test-only, check low key bit, required value
  typedef struct packed {
    logic legal;
    logic test;
    logic chk;
    logic val;
  } ent_t;

  function automatic ent_t make_ent(input int unsigned idx, input bit is_long,
                                    input int unsigned idx_w);
    ent_t e;
    int unsigned all1;
    all1 = (32'd1 << idx_w) - 1;
    e = '0;
    if (is_long) begin
      e.legal = ((idx >> (idx_w - 2)) != 3);
    end else begin
      e.legal = (idx != all1);
      e.test  = e.legal && ((idx >> (idx_w - 3)) == 7);
      e.chk   = e.test;
      e.val   = 1'b0;
    end
    return e;
  endfunction

endpackage

// File: rtl/bdisp_optab.sv
module bdisp_optab
  import bdisp_pkg::*;
#(
  parameter int IDX_W   = 6,
  parameter bit IS_LONG = 1'b0
) (
  input  logic [IDX_W:0] key,
  output logic           legal,
  output logic           test
);
  localparam int DEPTH = 1 << IDX_W;

  ent_t rom [DEPTH];
  ent_t ent;
  logic hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign rom[g] = make_ent(g, IS_LONG, IDX_W);
  end

  assign ent   = rom[key[IDX_W:1]];
  assign hit   = ent.legal && (!ent.chk || (key[0] == ent.val));
  assign legal = hit;
  assign test  = hit && ent.test;
endmodule

// File: rtl/bdisp_plan.sv
module bdisp_plan
  import bdisp_pkg::*;
#(
  parameter int BODY_W  = 30,
  parameter int SHORT_W = 15
) (
  input  logic [1:0]         fmt,
  input  logic [BODY_W-1:0]  body,
  input  logic               long_ok,
  input  logic               l_ok,
  input  logic               l_test,
  input  logic               r_ok,
  input  logic               r_test,
  output logic               p_fault,
  output tag_e               p_tag,
  output logic [BODY_W-1:0]  p_data,
  output tag_e               p_hold_tag,
  output logic [SHORT_W-1:0] p_hold,
  output logic               p_hold_ok,
  output st_e                p_next
);
  localparam int PAD_W = BODY_W - SHORT_W;

  logic [SHORT_W-1:0] lf, rf;
  assign lf = body[BODY_W-1:SHORT_W];
  assign rf = body[SHORT_W-1:0];

  always_comb begin
    p_fault    = 1'b0;
    p_tag      = TG_NONE;
    p_data     = '0;
    p_hold_tag = TG_NONE;
    p_hold     = '0;
    p_hold_ok  = 1'b0;
    p_next     = ST_IDLE;
    unique case (fmt)
      2'b11: begin
        p_fault = !long_ok;
        p_tag   = TG_LONG;
        p_data  = body;
      end
      2'b10: begin
        p_fault    = !r_ok;
        p_tag      = TG_RIGHT;
        p_data     = {{PAD_W{1'b0}}, rf};
        p_hold_tag = TG_LEFT;
        p_hold     = lf;
        p_hold_ok  = l_ok;
        p_next     = ST_SEQ2;
      end
      2'b01: begin
        p_fault    = !l_ok;
        p_tag      = TG_LEFT;
        p_data     = {{PAD_W{1'b0}}, lf};
        p_hold_tag = TG_RIGHT;
        p_hold     = rf;
        p_hold_ok  = r_ok;
        p_next     = ST_SEQ2;
      end
      default: begin
        p_fault   = !(l_ok && r_ok);
        p_hold_ok = 1'b1;
        if (l_test) begin
          p_tag      = TG_CTEST;
          p_data     = {{PAD_W{1'b0}}, lf};
          p_hold_tag = TG_CEXEC;
          p_hold     = rf;
          p_next     = ST_COND;
        end else if (r_test) begin
          p_tag      = TG_CTEST;
          p_data     = {{PAD_W{1'b0}}, rf};
          p_hold_tag = TG_CEXEC;
          p_hold     = lf;
          p_next     = ST_COND;
        end else begin
          p_tag      = TG_PAR;
          p_data     = {{PAD_W{1'b0}}, lf};
          p_hold_tag = TG_PAR;
          p_hold     = rf;
          p_next     = ST_PAR2;
        end
      end
    endcase
    if (p_fault) p_next = ST_IDLE;
  end
endmodule

// File: rtl/bdisp_top.sv
module bdisp_top
  import bdisp_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_i,
  output logic              in_ready,
  input  logic              pc_changed,
  input  logic              cond_true,
  output logic              op_valid,
  output logic [2:0]        op_tag,
  output logic [WORD_W-3:0] op_data,
  output logic              fault
);
  localparam int BODY_W  = WORD_W - 2;
  localparam int SHORT_W = BODY_W / 2;
  localparam int PAD_W   = BODY_W - SHORT_W;

  logic [1:0]        fmt;
  logic [BODY_W-1:0] body;
  assign fmt  = word_i[WORD_W-1 -: 2];
  assign body = word_i[BODY_W-1:0];

  // opcode lookups: long on top body bits, shorts on top bits of each field
  logic long_ok, long_test, l_ok, l_test, r_ok, r_test;

  bdisp_optab #(.IDX_W(IDX_W), .IS_LONG(1'b1)) i_tab_long (
    .key(body[BODY_W-1 -: IDX_W+1]), .legal(long_ok), .test(long_test));
  bdisp_optab #(.IDX_W(IDX_W), .IS_LONG(1'b0)) i_tab_left (
    .key(body[BODY_W-1 -: IDX_W+1]), .legal(l_ok), .test(l_test));
  bdisp_optab #(.IDX_W(IDX_W), .IS_LONG(1'b0)) i_tab_right (
    .key(body[SHORT_W-1 -: IDX_W+1]), .legal(r_ok), .test(r_test));

  logic               p_fault, p_hold_ok;
  tag_e               p_tag, p_hold_tag;
  logic [BODY_W-1:0]  p_data;
  logic [SHORT_W-1:0] p_hold;
  st_e                p_next;

  bdisp_plan #(.BODY_W(BODY_W), .SHORT_W(SHORT_W)) i_plan (
    .fmt(fmt), .body(body), .long_ok(long_ok && !long_test),
    .l_ok(l_ok), .l_test(l_test), .r_ok(r_ok), .r_test(r_test),
    .p_fault(p_fault), .p_tag(p_tag), .p_data(p_data),
    .p_hold_tag(p_hold_tag), .p_hold(p_hold), .p_hold_ok(p_hold_ok),
    .p_next(p_next));

  st_e                state;
  tag_e               hold_tag;
  logic [SHORT_W-1:0] hold;
  logic               hold_ok;
  tag_e               tag_q;

  assign in_ready = (state == ST_IDLE);
  assign op_tag   = tag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      hold_tag <= TG_NONE;
      hold     <= '0;
      hold_ok  <= 1'b0;
      op_valid <= 1'b0;
      tag_q    <= TG_NONE;
      op_data  <= '0;
      fault    <= 1'b0;
    end else begin
      op_valid <= 1'b0;
      tag_q    <= TG_NONE;
      op_data  <= '0;
      fault    <= 1'b0;
      state    <= ST_IDLE;
      unique case (state)
        ST_IDLE: if (word_valid) begin
          fault    <= p_fault;
          op_valid <= !p_fault;
          tag_q    <= p_fault ? TG_NONE : p_tag;
          op_data  <= p_fault ? '0 : p_data;
          state    <= p_next;
          hold_tag <= p_hold_tag;
          hold     <= p_hold;
          hold_ok  <= p_hold_ok;
        end
        ST_SEQ2: begin
          if (pc_changed) begin
            tag_q <= TG_SKIP;
          end else if (!hold_ok) begin
            fault <= 1'b1;
          end else begin
            op_valid <= 1'b1;
            tag_q    <= hold_tag;
            op_data  <= {{PAD_W{1'b0}}, hold};
          end
        end
        ST_COND: begin
          if (cond_true) begin
            op_valid <= 1'b1;
            tag_q    <= hold_tag;
            op_data  <= {{PAD_W{1'b0}}, hold};
          end else begin
            tag_q <= TG_SKIP;
          end
        end
        default: begin
          op_valid <= 1'b1;
          tag_q    <= hold_tag;
          op_data  <= {{PAD_W{1'b0}}, hold};
        end
      endcase
    end
  end

  p_fault_excl_r8: assert property (@(posedge clk) disable iff (rst)
    fault |-> (!op_valid && op_tag == 3'd0));

  p_valid_tag_r11: assert property (@(posedge clk) disable iff (rst)
    op_valid |-> (op_tag != 3'd0 && op_tag != 3'd7));

  p_busy_once_r9: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> in_ready);

  p_long_issue_r1: assert property (@(posedge clk) disable iff (rst)
    (in_ready && word_valid && word_i[WORD_W-1 -: 2] == 2'b11 &&
     word_i[BODY_W-1 -: 2] != 2'b11)
    |=> (op_valid && op_tag == 3'd1 && op_data == $past(word_i[BODY_W-1:0])));

  p_branch_skip_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SEQ2 && pc_changed) |=> (!op_valid && op_tag == 3'd7));

  p_par_pair_r5: assert property (@(posedge clk) disable iff (rst)
    (op_tag == 3'd4 && !in_ready) |=> (op_valid && op_tag == 3'd4));

  p_cond_follow_r6: assert property (@(posedge clk) disable iff (rst)
    (op_tag == 3'd5) |=> ((op_tag == 3'd6 || op_tag == 3'd7) &&
                          ((op_tag == 3'd6) == $past(cond_true))));
endmodule

// File: tb/test_bdisp_top.sv
module test_bdisp_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        word_valid;
  logic [31:0] word_i;
  logic        in_ready;
  logic        pc_changed;
  logic        cond_true;
  logic        op_valid;
  logic [2:0]  op_tag;
  logic [29:0] op_data;
  logic        fault;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [2:0] T_NONE = 0, T_LONG = 1, T_LEFT = 2, T_RIGHT = 3,
                         T_PAR = 4, T_CTEST = 5, T_CEXEC = 6, T_SKIP = 7;

  // short operations (15-bit fields), classified by R7
  localparam logic [14:0] OP_A    = 15'h1234; // index 9, plain
  localparam logic [14:0] OP_B    = 15'h0ABC; // index 5, plain
  localparam logic [14:0] OP_T    = 15'h7055; // index 56, bit 8 = 0, test-only
  localparam logic [14:0] OP_T2   = 15'h7255; // index 57, bit 8 = 0, test-only
  localparam logic [14:0] OP_BAD  = 15'h7F00; // index 63, illegal
  localparam logic [14:0] OP_TBAD = 15'h7155; // index 56, bit 8 = 1, no match

  always #10 clk = ~clk; // 50 MHz

  bdisp_top i_bdisp_top (
    .clk(clk), .rst(rst), .word_valid(word_valid), .word_i(word_i),
    .in_ready(in_ready), .pc_changed(pc_changed), .cond_true(cond_true),
    .op_valid(op_valid), .op_tag(op_tag), .op_data(op_data), .fault(fault));

  function automatic logic [34:0] ev(bit f, bit v, logic [2:0] t, logic [29:0] d);
    return {f, v, t, d};
  endfunction

  function automatic logic [29:0] sx(logic [14:0] s);
    return {15'b0, s};
  endfunction

  task automatic chk(string req, logic [34:0] exp);
    logic [34:0] act;
    act = {fault, op_valid, op_tag, op_data};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got fault/valid/tag/data=%h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_rdy(string req, logic exp);
    checks++;
    if (in_ready !== exp) begin
      errors++;
      $display("FAIL %s: in_ready got %b expected %b", req, in_ready, exp);
    end
  endtask

  task automatic put(logic [31:0] w);
    @(negedge clk);
    word_i = w;
    word_valid = 1'b1;
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  task automatic step(bit pc, bit cnd);
    pc_changed = pc;
    cond_true = cnd;
    @(negedge clk);
    pc_changed = 1'b0;
    cond_true = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 reset outputs", ev(0, 0, T_NONE, 0));
    chk_rdy("R10 reset ready", 1'b1);
  endtask

  task automatic t_long;
    put({2'b11, 30'h0123_4567});
    chk("R1 long issue", ev(0, 1, T_LONG, 30'h0123_4567));
    chk_rdy("R1 no busy after long", 1'b1);
    put({2'b11, 30'h3000_0001});
    chk("R7 R8 long bits29:28=11 faults", ev(1, 0, T_NONE, 0));
  endtask

  task automatic t_seq;
    put({2'b10, OP_A, OP_B});
    chk("R2 right first", ev(0, 1, T_RIGHT, sx(OP_B)));
    chk_rdy("R9 busy during pair", 1'b0);
    step(0, 0);
    chk("R2 left second", ev(0, 1, T_LEFT, sx(OP_A)));
    put({2'b01, OP_A, OP_B});
    chk("R3 left first", ev(0, 1, T_LEFT, sx(OP_A)));
    step(0, 0);
    chk("R3 right second", ev(0, 1, T_RIGHT, sx(OP_B)));
  endtask

  task automatic t_branch;
    put({2'b01, OP_A, OP_B});
    chk("R4 first issued", ev(0, 1, T_LEFT, sx(OP_A)));
    step(1, 0);
    chk("R4 second skipped on branch", ev(0, 0, T_SKIP, 0));
    put({2'b01, OP_A, OP_BAD});
    step(1, 0);
    chk("R8 illegal second skipped without fault", ev(0, 0, T_SKIP, 0));
    put({2'b01, OP_A, OP_BAD});
    step(0, 0);
    chk("R8 illegal second faults", ev(1, 0, T_NONE, 0));
    put({2'b10, OP_A, OP_BAD});
    chk("R8 illegal first drops word", ev(1, 0, T_NONE, 0));
    @(negedge clk);
    chk("R8 nothing after dropped word", ev(0, 0, T_NONE, 0));
  endtask

  task automatic t_par;
    put({2'b00, OP_A, OP_B});
    chk("R5 parallel left", ev(0, 1, T_PAR, sx(OP_A)));
    step(0, 0);
    chk("R5 parallel right", ev(0, 1, T_PAR, sx(OP_B)));
  endtask

  task automatic t_cond;
    put({2'b00, OP_T, OP_B});
    chk("R6 left test first", ev(0, 1, T_CTEST, sx(OP_T)));
    step(0, 1);
    chk("R6 right executes on true", ev(0, 1, T_CEXEC, sx(OP_B)));
    put({2'b00, OP_T, OP_B});
    step(0, 0);
    chk("R6 right skipped on false", ev(0, 0, T_SKIP, 0));
    put({2'b00, OP_A, OP_T});
    chk("R6 right test first", ev(0, 1, T_CTEST, sx(OP_T)));
    step(0, 1);
    chk("R6 left executes after right test", ev(0, 1, T_CEXEC, sx(OP_A)));
    put({2'b00, OP_T2, OP_T});
    chk("R6 left test wins when both test", ev(0, 1, T_CTEST, sx(OP_T2)));
    step(0, 1);
    chk("R6 right after both-test", ev(0, 1, T_CEXEC, sx(OP_T)));
  endtask

  task automatic t_table;
    put({2'b00, OP_TBAD, OP_B});
    chk("R7 R8 test index with bit8 set faults", ev(1, 0, T_NONE, 0));
    @(negedge clk);
    chk("R8 no issue after parallel fault", ev(0, 0, T_NONE, 0));
    chk_rdy("R8 ready after fault", 1'b1);
    put({2'b00, OP_A, OP_BAD});
    chk("R7 R8 short index 63 faults", ev(1, 0, T_NONE, 0));
  endtask

  task automatic t_busy;
    put({2'b01, OP_A, OP_B});
    word_i = {2'b11, 30'h0000_0042};
    word_valid = 1'b1;
    step(0, 0);
    word_valid = 1'b0;
    chk("R9 second issued while word offered", ev(0, 1, T_RIGHT, sx(OP_B)));
    @(negedge clk);
    chk("R9 busy-cycle word not taken", ev(0, 0, T_NONE, 0));
  endtask

  initial begin
    rst = 1'b1;
    word_valid = 1'b0;
    word_i = '0;
    pc_changed = 1'b0;
    cond_true = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_long();
    t_seq();
    t_branch();
    t_par();
    t_cond();
    t_table();
    t_busy();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule